// File: doc/BRIEF.md
# Unlock-Sequence Write Protection Detector

This block sits in front of the page-load logic of a nonvolatile memory and looks at every write on its address and data bus. It recognises fixed multi-write command prefixes. One prefix arms the protection flag and also opens a load window for the data writes that follow it. A longer prefix disarms the flag and opens a load window in the same way. Each write gets a verdict one cycle later: either it is passed on to the page buffer, or it is dropped. A dropped write that was not a command step, made while protection is on, also tells the page-write controller to run a dummy write-cycle timer, so that reads during that time behave as status polling.

The controller reports the end of each internal write period with a one-cycle pulse. A change to the protection flag that a prefix requested takes effect only on that pulse. This holds even when no data writes follow the prefix. Each command step, and each write in a load window, must arrive within a parameterised number of cycles of the write before it. Otherwise the matcher falls back to idle. On reset, the flag is loaded from an input that stands in for its nonvolatile copy, so a fresh part starts unprotected.

Top module: `wprot_detect`

## Requirements
- R1: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555 (15-bit address, 8-bit data) form the arm prefix. Every write that follows it inside the load window is accepted, even while protection is on and even if it looks like a command byte. Protection turns on at the next end-of-period pulse.
- R2: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, 0x20 to 0x5555 form the disarm prefix. It opens a load window, and protection turns off at the next end-of-period pulse.
- R3: The protection flag changes only on the cycle_done pulse. A pending change is applied at that pulse even if no data write followed the prefix.
- R4: While protection is on, a write that is neither a command step nor inside a load window is discarded, and timer_start is raised with the discard.
- R5: A write that advances the matcher by one command step is discarded without timer_start, whatever the protection state.
- R6: While protection is off, an ordinary write is accepted without timer_start.
- R7: A write that does not match the next expected step returns the matcher to idle. That write is then judged as an ordinary write under the current protection state, and the step it broke is not resumed.
- R8: With LOAD_WIN = W, a write that comes at most W cycles after the previous command or window write continues the sequence. After W write-free cycles the matcher is idle.
- R9: Reset loads the flag from prot_init, clears any pending change, returns the matcher to idle and holds all verdict outputs low.
- R10: Each write produces, on the following cycle, exactly one of wr_accept and wr_discard. A cycle without a write produces neither, and no timer_start.
- R11: If a second prefix completes before the end-of-period pulse, the later prefix decides the flag value that the pulse applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_init | input | 1 | Stored protection value loaded at reset |
| wr_valid | input | 1 | A write is present this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| cycle_done | input | 1 | End of internal write period, one-cycle pulse |
| wr_accept | output | 1 | Previous cycle's write goes to the page buffer |
| wr_discard | output | 1 | Previous cycle's write is dropped |
| timer_start | output | 1 | Start a dummy write-cycle timer for a blocked write |
| prot_active | output | 1 | Current protection state |

## Verification
The bench places writes exactly W and W+1 cycles apart. A design with an off-by-one window would either accept a late data write or refuse one that came in time. It breaks prefixes half-way and sends the step that would have completed them. A matcher that did not return to idle would then wrongly unlock a protected write. It also checks that a code-like byte inside an open window is stored, that the flag does not move until the end-of-period pulse, that an arm followed by a disarm before that pulse leaves protection off, and that a reset in the middle of a prefix forgets the steps already seen.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam logic [14:0] KEY_ADDR_HI = 15'h5555;
    localparam logic [14:0] KEY_ADDR_LO = 15'h2AAA;
    localparam logic [7:0]  CODE_LEAD   = 8'hAA;
    localparam logic [7:0]  CODE_SECOND = 8'h55;
    localparam logic [7:0]  CODE_ARM    = 8'hA0;
    localparam logic [7:0]  CODE_EXTEND = 8'h80;
    localparam logic [7:0]  CODE_DISARM = 8'h20;

    typedef enum logic [2:0] {
        M_IDLE, M_K1, M_K2, M_OPEN, M_D3, M_D4, M_D5
    } mstate_t;

    typedef enum logic [1:0] {WC_NONE, WC_CMD, WC_OPEN, WC_PLAIN} wclass_t;

    typedef enum logic [1:0] {PD_NONE, PD_ARM, PD_DISARM} pend_t;

    typedef struct packed {
        logic    hit;
        mstate_t nxt;
        pend_t   evt;
    } step_t;

    typedef struct packed {
        logic accept;
        logic discard;
        logic kick;
    } verdict_t;

    function automatic step_t cmd_step(mstate_t s, logic at_hi, logic at_lo, logic [7:0] d);
        step_t r;
        r.hit = 1'b0;
        r.nxt = M_IDLE;
        r.evt = PD_NONE;
        case (s)
            M_IDLE: if (at_hi && d == CODE_LEAD)   begin r.hit = 1'b1; r.nxt = M_K1; end
            M_K1:   if (at_lo && d == CODE_SECOND) begin r.hit = 1'b1; r.nxt = M_K2; end
            M_K2: begin
                if (at_hi && d == CODE_ARM) begin
                    r.hit = 1'b1; r.nxt = M_OPEN; r.evt = PD_ARM;
                end else if (at_hi && d == CODE_EXTEND) begin
                    r.hit = 1'b1; r.nxt = M_D3;
                end
            end
            M_D3:   if (at_hi && d == CODE_LEAD)   begin r.hit = 1'b1; r.nxt = M_D4; end
            M_D4:   if (at_lo && d == CODE_SECOND) begin r.hit = 1'b1; r.nxt = M_D5; end
            M_D5: begin
                if (at_hi && d == CODE_DISARM) begin
                    r.hit = 1'b1; r.nxt = M_OPEN; r.evt = PD_DISARM;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wprot_seq_match.sv
module wprot_seq_match
    import wprot_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int LOAD_WIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wclass_t           wr_class,
    output pend_t             cmd_evt
);
    localparam int CNT_W = $clog2(LOAD_WIN + 1);

    mstate_t           state;
    logic [CNT_W-1:0]  gap_cnt;
    logic              hi_clear;
    logic              at_hi;
    logic              at_lo;
    step_t             st;

    generate
        if (DATA_W > 8) begin : g_wide
            assign hi_clear = ~|wr_data[DATA_W-1:8];
        end else begin : g_byte
            assign hi_clear = 1'b1;
        end
    endgenerate

    assign at_hi = hi_clear && (wr_addr == ADDR_W'(KEY_ADDR_HI));
    assign at_lo = hi_clear && (wr_addr == ADDR_W'(KEY_ADDR_LO));

    always_comb begin
        st       = cmd_step(state, at_hi, at_lo, wr_data[7:0]);
        wr_class = WC_NONE;
        cmd_evt  = PD_NONE;
        if (wr_valid) begin
            if (state == M_OPEN) begin
                wr_class = WC_OPEN;
            end else if (st.hit) begin
                wr_class = WC_CMD;
                cmd_evt  = st.evt;
            end else begin
                wr_class = WC_PLAIN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= M_IDLE;
            gap_cnt <= '0;
        end else if (wr_valid) begin
            gap_cnt <= '0;
            if (state == M_OPEN) state <= M_OPEN;
            else if (st.hit)     state <= st.nxt;
            else                 state <= M_IDLE;
        end else if (state != M_IDLE) begin
            if (gap_cnt == CNT_W'(LOAD_WIN - 1)) begin
                state   <= M_IDLE;
                gap_cnt <= '0;
            end else begin
                gap_cnt <= gap_cnt + CNT_W'(1);
            end
        end
    end

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        gap_cnt < CNT_W'(LOAD_WIN)); // R8
    AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == M_OPEN && wr_valid) |=> state == M_OPEN); // R1
    AST_BREAK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_class == WC_PLAIN) |=> state == M_IDLE); // R7

endmodule

// File: rtl/wprot_flag.sv
module wprot_flag
    import wprot_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  prot_init,
    input  pend_t cmd_evt,
    input  logic  cycle_done,
    output logic  prot
);
    pend_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= prot_init;
            pend <= PD_NONE;
        end else begin
            if (cycle_done) begin
                if (pend == PD_ARM)         prot <= 1'b1;
                else if (pend == PD_DISARM) prot <= 1'b0;
                pend <= PD_NONE;
            end
            if (cmd_evt != PD_NONE) pend <= cmd_evt;
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cycle_done |=> $stable(prot)); // R3
    AST_ARM_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cycle_done && pend == PD_ARM) |=> prot); // R1
    AST_DISARM_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cycle_done && pend == PD_DISARM) |=> !prot); // R2

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wclass_t  wr_class,
    input  logic     prot,
    output verdict_t verdict
);
    verdict_t nxt;

    always_comb begin
        nxt = '0;
        case (wr_class)
            WC_CMD:   nxt.discard = 1'b1;
            WC_OPEN:  nxt.accept  = 1'b1;
            WC_PLAIN: begin
                if (prot) begin
                    nxt.discard = 1'b1;
                    nxt.kick    = 1'b1;
                end else begin
                    nxt.accept  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) verdict <= '0;
        else     verdict <= nxt;
    end

    AST_CMD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_class == WC_CMD) |=> (verdict.discard && !verdict.accept && !verdict.kick)); // R5
    AST_BLOCKED_KICK: assert property (@(posedge clk) disable iff (rst)
        (wr_class == WC_PLAIN && prot) |=> (verdict.discard && verdict.kick)); // R4
    AST_OPEN_PASS: assert property (@(posedge clk) disable iff (rst)
        (wr_class == WC_PLAIN && !prot) |=> (verdict.accept && !verdict.kick)); // R6
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (wr_class != WC_NONE) |=> (verdict.accept ^ verdict.discard)); // R10
    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_class == WC_NONE) |=> (verdict == '0)); // R10

endmodule

// File: rtl/wprot_detect.sv
module wprot_detect
    import wprot_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int LOAD_WIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_init,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_done,
    output logic              wr_accept,
    output logic              wr_discard,
    output logic              timer_start,
    output logic              prot_active
);
    wclass_t  wr_class;
    pend_t    cmd_evt;
    logic     prot;
    verdict_t verdict;

    wprot_seq_match #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .LOAD_WIN(LOAD_WIN)
    ) u_match (
        .clk     (clk),
        .rst     (rst),
        .wr_valid(wr_valid),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_class(wr_class),
        .cmd_evt (cmd_evt)
    );

    wprot_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .prot_init (prot_init),
        .cmd_evt   (cmd_evt),
        .cycle_done(cycle_done),
        .prot      (prot)
    );

    wprot_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .wr_class(wr_class),
        .prot    (prot),
        .verdict (verdict)
    );

    assign wr_accept   = verdict.accept;
    assign wr_discard  = verdict.discard;
    assign timer_start = verdict.kick;
    assign prot_active = prot;

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (prot_active == $past(prot_init) && !wr_accept && !wr_discard && !timer_start)); // R9

endmodule

// File: tb/wprot_detect_tb.sv
module wprot_detect_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 4;
    localparam int NV = 51;

    typedef struct packed {
        logic        v;
        logic [14:0] a;
        logic [7:0]  d;
        logic        cd;
        logic [3:0]  rep;
        logic        acc;
        logic        drp;
        logic        kick;
        logic        prot;
        logic [3:0]  req;
    } vec_t;

    localparam logic Y = 1'b1;
    localparam logic N = 1'b0;
    localparam logic [14:0] HI = 15'h5555;
    localparam logic [14:0] LO = 15'h2AAA;
    localparam logic [14:0] Z = 15'h0000;

    localparam vec_t VECS [NV] = '{
        '{Y, 15'h0100, 8'h11, N, 4'd1, Y, N, N, N, 4'd6},  // R6 plain write, unprotected
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, N, 4'd5},        // R5 command step dropped
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, N, 4'd5},        // R5
        '{Y, HI, 8'hA0, N, 4'd1, N, Y, N, N, 4'd1},        // R1 arm prefix complete
        '{Y, 15'h0200, 8'h33, N, 4'd1, Y, N, N, N, 4'd1},  // R1 window data
        '{Y, 15'h0201, 8'h34, N, 4'd1, Y, N, N, N, 4'd1},  // R1
        '{N, Z, 8'h00, Y, 4'd1, N, N, N, Y, 4'd3},         // R3 flag set on period end
        '{N, Z, 8'h00, N, 4'd2, N, N, N, Y, 4'd3},         // R3
        '{Y, 15'h0202, 8'h35, N, 4'd1, Y, N, N, Y, 4'd8},  // R8 write exactly WIN later
        '{N, Z, 8'h00, N, 4'd4, N, N, N, Y, 4'd10},        // R10 window expires
        '{Y, 15'h0300, 8'h44, N, 4'd1, N, Y, Y, Y, 4'd4},  // R4 blocked write
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, Y, 4'd5},        // R5
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, Y, 4'd5},        // R5
        '{Y, 15'h0400, 8'h77, N, 4'd1, N, Y, Y, Y, 4'd7},  // R7 mismatch judged protected
        '{Y, HI, 8'hA0, N, 4'd1, N, Y, Y, Y, 4'd7},        // R7 no resume
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, Y, 4'd1},        // R1
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, Y, 4'd1},        // R1
        '{Y, HI, 8'hA0, N, 4'd1, N, Y, N, Y, 4'd1},        // R1
        '{Y, 15'h0500, 8'h66, N, 4'd1, Y, N, N, Y, 4'd1},  // R1 unlocked while protected
        '{N, Z, 8'h00, N, 4'd4, N, N, N, Y, 4'd8},         // R8
        '{Y, 15'h0501, 8'h67, N, 4'd1, N, Y, Y, Y, 4'd4},  // R4 window closed
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, Y, 4'd5},        // R5
        '{N, Z, 8'h00, N, 4'd4, N, N, N, Y, 4'd8},         // R8 step too late
        '{Y, LO, 8'h55, N, 4'd1, N, Y, Y, Y, 4'd8},        // R8
        '{Y, HI, 8'hA0, N, 4'd1, N, Y, Y, Y, 4'd8},        // R8
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, Y, 4'd2},        // R2 disarm prefix
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, Y, 4'd2},        // R2
        '{Y, HI, 8'h80, N, 4'd1, N, Y, N, Y, 4'd2},        // R2
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, Y, 4'd2},        // R2
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, Y, 4'd2},        // R2
        '{Y, HI, 8'h20, N, 4'd1, N, Y, N, Y, 4'd2},        // R2
        '{N, Z, 8'h00, N, 4'd1, N, N, N, Y, 4'd3},         // R3 not yet
        '{N, Z, 8'h00, Y, 4'd1, N, N, N, N, 4'd2},         // R2 cleared with no data
        '{N, Z, 8'h00, N, 4'd2, N, N, N, N, 4'd2},         // R2
        '{Y, 15'h0600, 8'h70, N, 4'd1, Y, N, N, N, 4'd6},  // R6
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, N, 4'd11},       // R11 arm first
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, N, 4'd11},       // R11
        '{Y, HI, 8'hA0, N, 4'd1, N, Y, N, N, 4'd11},       // R11
        '{Y, HI, 8'hAA, N, 4'd1, Y, N, N, N, 4'd1},        // R1 code byte inside window stored
        '{N, Z, 8'h00, N, 4'd4, N, N, N, N, 4'd8},         // R8
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, N, 4'd11},       // R11 then disarm
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, N, 4'd11},       // R11
        '{Y, HI, 8'h80, N, 4'd1, N, Y, N, N, 4'd11},       // R11
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, N, 4'd11},       // R11
        '{Y, LO, 8'h55, N, 4'd1, N, Y, N, N, 4'd11},       // R11
        '{Y, HI, 8'h20, N, 4'd1, N, Y, N, N, 4'd11},       // R11
        '{N, Z, 8'h00, Y, 4'd1, N, N, N, N, 4'd11},        // R11 later prefix wins
        '{N, Z, 8'h00, N, 4'd3, N, N, N, N, 4'd8},         // R8
        '{Y, HI, 8'hAA, N, 4'd1, N, Y, N, N, 4'd5},        // R5
        '{Y, HI, 8'h99, N, 4'd1, Y, N, N, N, 4'd7},        // R7 mismatch judged unprotected
        '{Y, LO, 8'h55, N, 4'd1, Y, N, N, N, 4'd7}         // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot_init = 1'b0;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cycle_done = 1'b0;
    logic        wr_accept, wr_discard, timer_start, prot_active;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wprot_detect #(
        .ADDR_W  (15),
        .DATA_W  (8),
        .LOAD_WIN(WIN)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .prot_init  (prot_init),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cycle_done (cycle_done),
        .wr_accept  (wr_accept),
        .wr_discard (wr_discard),
        .timer_start(timer_start),
        .prot_active(prot_active)
    );

    task automatic expect4(input int req, input logic acc, input logic drp,
                           input logic kick, input logic prot);
        checks++;
        if ({wr_accept, wr_discard, timer_start, prot_active} !== {acc, drp, kick, prot}) begin
            errors++;
            $display("FAIL R%0d at %0t: acc/drp/kick/prot actual %b%b%b%b expected %b%b%b%b",
                     req, $time, wr_accept, wr_discard, timer_start, prot_active,
                     acc, drp, kick, prot);
        end
    endtask

    task automatic cyc(input logic v, input logic [14:0] a, input logic [7:0] d, input logic cd);
        @(negedge clk);
        wr_valid   = v;
        wr_addr    = a;
        wr_data    = d;
        cycle_done = cd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R9 reset state, unprotected stored value
        cyc(N, Z, 8'h00, N);
        cyc(N, Z, 8'h00, N);
        expect4(9, N, N, N, N);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < int'(VECS[i].rep); k++) begin
                cyc(VECS[i].v, VECS[i].a, VECS[i].d, VECS[i].cd);
                expect4(int'(VECS[i].req), VECS[i].acc, VECS[i].drp,
                        VECS[i].kick, VECS[i].prot);
            end
        end
        cyc(N, Z, 8'h00, N);
        expect4(10, N, N, N, N);                   // R10 idle cycle is quiet

        // R9 reset loads protected stored value; write presented during reset is ignored
        @(negedge clk);
        rst = 1'b1;
        prot_init = 1'b1;
        cyc(Y, 15'h0700, 8'h01, N);
        expect4(9, N, N, N, Y);
        @(negedge clk);
        rst = 1'b0;
        cyc(Y, 15'h0700, 8'h01, N);
        expect4(9, N, Y, Y, Y);                    // R4 after reset from stored value

        // R9 reset in the middle of a prefix forgets the steps seen
        cyc(Y, HI, 8'hAA, N);
        expect4(5, N, Y, N, Y);
        cyc(Y, LO, 8'h55, N);
        expect4(5, N, Y, N, Y);
        @(negedge clk);
        rst = 1'b1;
        cyc(N, Z, 8'h00, N);
        expect4(9, N, N, N, Y);
        @(negedge clk);
        rst = 1'b0;
        cyc(Y, HI, 8'hA0, N);
        expect4(9, N, Y, Y, Y);
        cyc(N, Z, 8'h00, Y);
        expect4(3, N, N, N, Y);                    // R3 period end with nothing pending

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog: actual run still busy, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule